// File: doc/BRIEF.md
# Hash Mode Word Checker

This block sits in front of a message-digest engine. It inspects the 64-bit mode word that comes with each descriptor and turns it into registered per-descriptor controls: initialize the digest, autopad and finalize, keyed HMAC, SSL-style MAC, and compare the integrity check value (ICV). Each word is checked against a set of legality rules. Some rules look only at the word itself. Others look at the chain of descriptors that together hash one long message. A broken rule suppresses the controls for that descriptor and sets a sticky error flag.

A chain opens when a descriptor is accepted with its continue bit set. It closes when the next accepted descriptor has that bit clear. Along with the word, the surrounding logic supplies three side flags. The first says whether the descriptor type can read an incoming ICV. The second says whether an intermediate digest context is supplied. The third says whether a key with its length is supplied. The block does no hashing. It only decides, sequences and flags.

Top module: `hmc_mode_check`

## Requirements
- R1: The mode word is laid out as follows. Bits [3:0] hold the algorithm select. Bit 4 is PD, bit 5 is HMAC, bit 6 is INIT, bit 7 is SMAC, bit 8 is CICV and bit 9 is CONT. For a descriptor with no fault, the outputs appear one clock after `mode_valid`: `out_valid`=1, `do_init`=INIT, `do_final`=NOT CONT, `do_hmac`=HMAC, `do_smac`=SMAC, `do_cicv`=CICV and `alg`=bits [3:0].
- R2: Any nonzero bit in [63:10] sets `fault` bit 0.
- R3: PD equal to CONT sets `fault` bit 1.
- R4: HMAC and SMAC both set sets `fault` bit 2.
- R5: HMAC or SMAC set while `key_ok`=0 sets `fault` bit 3.
- R6: CICV set while `icv_ok`=0 sets `fault` bit 4.
- R7: CICV set together with CONT=1 sets `fault` bit 5.
- R8: INIT=1 while a chain is open sets `fault` bit 6.
- R9: INIT=0 while no chain is open and `ctx_ok`=0 sets `fault` bit 7.
- R10: A descriptor with any fault produces `desc_err`=1 and all controls and `alg` at zero, and it leaves `chain_open` unchanged. An accepted descriptor sets `chain_open` to its CONT bit, on the same edge as its outputs.
- R11: `err_flag` is set by any faulty descriptor. It stays set until a cycle in which `err_clr`=1 and no new fault arrives. Reset clears every output, including `chain_open` and `err_flag`.
- R12: In a cycle after one without `mode_valid`, `out_valid`, `desc_err`, `fault` and all controls are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_valid | input | 1 | Mode word present this cycle |
| mode_word | input | 64 | Descriptor mode word |
| icv_ok | input | 1 | Descriptor type can read an incoming ICV |
| ctx_ok | input | 1 | Intermediate digest context supplied |
| key_ok | input | 1 | Key and key length supplied |
| err_clr | input | 1 | Pulse to clear the sticky error flag |
| out_valid | output | 1 | Decoded result valid |
| do_init | output | 1 | Run algorithm initialization of digest |
| do_final | output | 1 | Autopad and complete the digest |
| do_hmac | output | 1 | HMAC operation |
| do_smac | output | 1 | SSL-style MAC operation |
| do_cicv | output | 1 | Compare computed ICV against input |
| alg | output | 4 | Algorithm select |
| fault | output | 8 | Per-descriptor rule violations |
| desc_err | output | 1 | This descriptor broke a rule |
| err_flag | output | 1 | Sticky error flag |
| chain_open | output | 1 | A multi-descriptor chain is in progress |

## Verification
The bench builds the block with its default parameters: a 64-bit word and a 4-bit algorithm field. With those values every rule bit sits at a fixed position, and reserved bits at both ends of the reserved range can be set. Every rule is violated alone and in combination. The sequences cover a chain that opens, continues, rejects a misplaced INIT and a premature ICV compare, and then closes. They also include a clear pulse that collides with a new fault.

// File: rtl/hmc_pkg.sv
package hmc_pkg;
  localparam int NFAULT   = 8;
  localparam int F_RSV    = 0;
  localparam int F_PD     = 1;
  localparam int F_BOTH   = 2;
  localparam int F_KEY    = 3;
  localparam int F_ICVTY  = 4;
  localparam int F_ICVCON = 5;
  localparam int F_INITM  = 6;
  localparam int F_NOCTX  = 7;

  typedef struct packed {
    logic cont;
    logic cicv;
    logic smac;
    logic init;
    logic hmac;
    logic pd;
  } hmc_flags_t;
endpackage

// File: rtl/hmc_decode.sv
module hmc_decode #(
  parameter int WORD_W = 64,
  parameter int ALG_W  = 4
) (
  input  logic [WORD_W-1:0]  word,
  output hmc_pkg::hmc_flags_t flags,
  output logic [ALG_W-1:0]   alg,
  output logic               rsv_nz
);
  localparam int PD_POS   = ALG_W;
  localparam int HMAC_POS = ALG_W + 1;
  localparam int INIT_POS = ALG_W + 2;
  localparam int SMAC_POS = ALG_W + 3;
  localparam int CICV_POS = ALG_W + 4;
  localparam int CONT_POS = ALG_W + 5;
  localparam int RSV_LO   = ALG_W + 6;

  always_comb begin
    flags.pd   = word[PD_POS];
    flags.hmac = word[HMAC_POS];
    flags.init = word[INIT_POS];
    flags.smac = word[SMAC_POS];
    flags.cicv = word[CICV_POS];
    flags.cont = word[CONT_POS];
    alg        = word[ALG_W-1:0];
    rsv_nz     = |word[WORD_W-1:RSV_LO];
  end
endmodule

// File: rtl/hmc_rules.sv
module hmc_rules (
  input  hmc_pkg::hmc_flags_t        flags,
  input  logic                       rsv_nz,
  input  logic                       icv_ok,
  input  logic                       ctx_ok,
  input  logic                       key_ok,
  input  logic                       chain_open,
  output logic [hmc_pkg::NFAULT-1:0] fault
);
  import hmc_pkg::*;
  always_comb begin
    fault           = '0;
    fault[F_RSV]    = rsv_nz;
    fault[F_PD]     = (flags.pd == flags.cont);
    fault[F_BOTH]   = flags.hmac & flags.smac;
    fault[F_KEY]    = (flags.hmac | flags.smac) & ~key_ok;
    fault[F_ICVTY]  = flags.cicv & ~icv_ok;
    fault[F_ICVCON] = flags.cicv & flags.cont;
    fault[F_INITM]  = flags.init & chain_open;
    fault[F_NOCTX]  = ~flags.init & ~chain_open & ~ctx_ok;
  end
endmodule

// File: rtl/hmc_state.sv
module hmc_state (
  input  logic clk,
  input  logic rst,
  input  logic accept,
  input  logic reject,
  input  logic cont,
  input  logic err_clr,
  output logic chain_open,
  output logic err_flag
);
  always_ff @(posedge clk) begin
    if (rst) begin
      chain_open <= 1'b0;
      err_flag   <= 1'b0;
    end else begin
      if (accept) chain_open <= cont;
      if (reject) err_flag <= 1'b1;
      else if (err_clr) err_flag <= 1'b0;
    end
  end

  // R11
  sticky_err_chk: assert property (@(posedge clk) disable iff (rst)
    err_flag && !err_clr |=> err_flag);

  // R11
  err_set_chk: assert property (@(posedge clk) disable iff (rst)
    reject |=> err_flag);
endmodule

// File: rtl/hmc_mode_check.sv
module hmc_mode_check #(
  parameter int WORD_W = 64,
  parameter int ALG_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_valid,
  input  logic [WORD_W-1:0] mode_word,
  input  logic              icv_ok,
  input  logic              ctx_ok,
  input  logic              key_ok,
  input  logic              err_clr,
  output logic              out_valid,
  output logic              do_init,
  output logic              do_final,
  output logic              do_hmac,
  output logic              do_smac,
  output logic              do_cicv,
  output logic [ALG_W-1:0]  alg,
  output logic [7:0]        fault,
  output logic              desc_err,
  output logic              err_flag,
  output logic              chain_open
);
  import hmc_pkg::*;

  hmc_flags_t        flg;
  logic [ALG_W-1:0]  alg_c;
  logic              rsv_c;
  logic [NFAULT-1:0] fault_c;
  logic              any_f, accept, reject;

  hmc_decode #(.WORD_W(WORD_W), .ALG_W(ALG_W)) u_dec (
    .word(mode_word), .flags(flg), .alg(alg_c), .rsv_nz(rsv_c));

  hmc_rules u_rules (
    .flags(flg), .rsv_nz(rsv_c), .icv_ok(icv_ok), .ctx_ok(ctx_ok),
    .key_ok(key_ok), .chain_open(chain_open), .fault(fault_c));

  assign any_f  = |fault_c;
  assign accept = mode_valid & ~any_f;
  assign reject = mode_valid & any_f;

  hmc_state u_state (
    .clk(clk), .rst(rst), .accept(accept), .reject(reject),
    .cont(flg.cont), .err_clr(err_clr),
    .chain_open(chain_open), .err_flag(err_flag));

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      do_init   <= 1'b0;
      do_final  <= 1'b0;
      do_hmac   <= 1'b0;
      do_smac   <= 1'b0;
      do_cicv   <= 1'b0;
      alg       <= '0;
      fault     <= '0;
      desc_err  <= 1'b0;
    end else begin
      out_valid <= mode_valid;
      do_init   <= accept & flg.init;
      do_final  <= accept & ~flg.cont;
      do_hmac   <= accept & flg.hmac;
      do_smac   <= accept & flg.smac;
      do_cicv   <= accept & flg.cicv;
      alg       <= accept ? alg_c : '0;
      fault     <= mode_valid ? fault_c : '0;
      desc_err  <= reject;
    end
  end

  // R10
  chain_hold_chk: assert property (@(posedge clk) disable iff (rst)
    reject |=> $stable(chain_open));

  // R10
  suppress_chk: assert property (@(posedge clk) disable iff (rst)
    desc_err |-> !(do_init || do_final || do_hmac || do_smac || do_cicv));

  // R1
  final_chain_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !desc_err |-> (do_final == !chain_open));

  // R4
  mac_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(do_hmac && do_smac));

  // R12
  idle_chk: assert property (@(posedge clk) disable iff (rst)
    !mode_valid |=> !out_valid && !desc_err);
endmodule

// File: tb/hmc_mode_check_tb.sv
module hmc_mode_check_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_valid = 1'b0;
  logic [63:0] mode_word = '0;
  logic icv_ok = 1'b0, ctx_ok = 1'b0, key_ok = 1'b0, err_clr = 1'b0;
  logic out_valid, do_init, do_final, do_hmac, do_smac, do_cicv;
  logic [3:0] alg;
  logic [7:0] fault;
  logic desc_err, err_flag, chain_open;

  always #2 clk = ~clk;

  hmc_mode_check u_dut (
    .clk(clk), .rst(rst), .mode_valid(mode_valid), .mode_word(mode_word),
    .icv_ok(icv_ok), .ctx_ok(ctx_ok), .key_ok(key_ok), .err_clr(err_clr),
    .out_valid(out_valid), .do_init(do_init), .do_final(do_final),
    .do_hmac(do_hmac), .do_smac(do_smac), .do_cicv(do_cicv), .alg(alg),
    .fault(fault), .desc_err(desc_err), .err_flag(err_flag),
    .chain_open(chain_open));

  int checks = 0, errors = 0, cycles = 0;
  string drv_tag = "R11 reset", exp_tag = "R11 reset";
  logic [20:0] exp_v = '0;
  bit e_open = 0, e_err = 0, started = 0;

  function automatic logic [63:0] mk(bit cont, bit cicv, bit smac, bit init,
                                     bit hmac, bit pd, int a);
    logic [63:0] w = '0;
    w[9] = cont; w[8] = cicv; w[7] = smac; w[6] = init;
    w[5] = hmac; w[4] = pd; w[3:0] = a[3:0];
    return w;
  endfunction

  always @(posedge clk) begin
    bit [7:0] f;
    bit ok;
    exp_tag = drv_tag;
    started = 1;
    f = 0;
    if (rst) begin
      e_open = 0; e_err = 0; exp_v = '0;
    end else begin
      if (mode_word[63:10] != 0) f[0] = 1;
      if (mode_word[4] == mode_word[9]) f[1] = 1;
      if (mode_word[5] && mode_word[7]) f[2] = 1;
      if ((mode_word[5] || mode_word[7]) && !key_ok) f[3] = 1;
      if (mode_word[8] && !icv_ok) f[4] = 1;
      if (mode_word[8] && mode_word[9]) f[5] = 1;
      if (mode_word[6] && e_open) f[6] = 1;
      if (!mode_word[6] && !e_open && !ctx_ok) f[7] = 1;
      if (!mode_valid) f = 0;
      ok = mode_valid && (f == 0);
      if (ok)
        exp_v = {1'b1, mode_word[6], !mode_word[9], mode_word[5], mode_word[7],
                 mode_word[8], mode_word[3:0], 8'h00, 1'b0, 1'b0, 1'b0};
      else
        exp_v = {mode_valid, 5'b0, 4'b0, f, (f != 0), 1'b0, 1'b0};
      if (ok) e_open = mode_word[9];
      if (mode_valid && f != 0) e_err = 1;
      else if (err_clr) e_err = 0;
      exp_v[1] = e_err;
      exp_v[0] = e_open;
    end
  end

  always @(negedge clk) begin
    logic [20:0] act;
    if (started) begin
      act = {out_valid, do_init, do_final, do_hmac, do_smac, do_cicv, alg,
             fault, desc_err, err_flag, chain_open};
      checks++;
      if (act !== exp_v) begin
        errors++;
        $display("FAIL %s act=%h exp=%h", exp_tag, act, exp_v);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic send(logic [63:0] w, bit icv, bit ctx, bit key, bit clr,
                      string tag);
    @(negedge clk);
    mode_word = w; icv_ok = icv; ctx_ok = ctx; key_ok = key; err_clr = clr;
    mode_valid = 1'b1; drv_tag = tag;
    @(negedge clk);
    mode_valid = 1'b0; err_clr = 1'b0; mode_word = '0; drv_tag = "R12 idle";
  endtask

  task automatic clr_pulse(string tag);
    @(negedge clk);
    err_clr = 1'b1; drv_tag = tag;
    @(negedge clk);
    err_clr = 1'b0; drv_tag = "R12 idle";
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0; drv_tag = "R12 idle";
    repeat (2) @(negedge clk);
    send(mk(0,0,0,1,0,1,3), 0, 0, 0, 0, "R1 single plain");
    send(mk(0,0,0,1,1,1,9), 0, 0, 1, 0, "R1 hmac keyed");
    send(mk(0,1,1,1,0,1,5), 1, 0, 1, 0, "R1 smac cicv");
    send(mk(0,0,0,1,1,1,1), 0, 0, 0, 0, "R5 hmac no key");
    clr_pulse("R11 clear");
    send(mk(0,0,1,1,1,1,2), 0, 0, 1, 0, "R4 both macs");
    send(mk(0,0,0,1,0,1,0) | 64'h8000_0000_0000_0000, 0, 0, 0, 0, "R2 top rsv");
    send(mk(0,0,0,1,0,1,0) | 64'h400, 0, 0, 0, 0, "R2 low rsv");
    send(mk(0,0,0,1,0,0,0), 0, 0, 0, 0, "R3 pd eq cont 0");
    send(mk(1,0,0,1,0,1,0), 0, 0, 0, 0, "R3 pd eq cont 1");
    send(mk(0,1,0,1,0,1,0), 0, 0, 0, 0, "R6 cicv no type");
    clr_pulse("R11 clear again");
    send(mk(1,0,0,1,0,0,4), 0, 0, 0, 0, "R10 chain open");
    send(mk(1,0,0,1,0,0,4), 0, 0, 0, 0, "R8 init mid chain");
    send(mk(1,0,0,0,0,0,4), 0, 0, 0, 0, "R10 chain middle");
    send(mk(1,1,0,0,0,0,4), 1, 0, 0, 0, "R7 cicv with cont");
    send(mk(0,1,0,0,0,1,4), 1, 0, 0, 1, "R11 clr with accept");
    send(mk(0,0,0,0,0,1,6), 0, 0, 0, 0, "R9 no ctx");
    send(mk(0,0,0,0,0,1,6), 0, 0, 0, 1, "R11 clr loses to fault");
    clr_pulse("R11 clear final");
    send(mk(0,0,0,0,0,1,7), 0, 1, 0, 0, "R9 ctx supplied ok");
    send(mk(1,0,0,0,0,0,8), 0, 1, 0, 0, "R10 open from ctx");
    @(negedge clk); rst = 1'b1; drv_tag = "R11 reset mid chain";
    @(negedge clk); rst = 1'b0; drv_tag = "R12 idle";
    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule